// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Video Receive Front End

This block is the control port of a serial-video receive front end. A host reaches it over a four-wire serial link (clock, data in, data out, active-low select) and uses it to set the muting, sleep behaviour, reach extension, output swing, output offset and launch-amplitude tuning of the analog core. Through the same link it reads back live status: whether a carrier is present and how much cable is being equalized. Each setting is presented to the core as its own decoded output field.

The serial pins are brought into the system clock domain through two-flop synchronisers, and their edges are found there. A frame opens with a command bit (0 write, 1 read) and a 7-bit address, both sent most significant bit first. A write frame then carries 8 data bits and takes effect on its 16th rising serial clock. A read frame turns the data line around: the addressed register is captured at the 8th rising edge and returned on the output, most significant bit first, beginning at the 8th falling edge. The output enable is raised only for that data phase. The map holds three writable registers and one status register; reserved and read-only fields are masked on write. An enable input blocks all access when it is low.

Top module: `spi_cfg_ctrl`

## Requirements
- R1: After reset the decoded fields are mute 0, sleep mode 01, reach extension 0, swing 011, offset 001, coarse 0 and fine 0000. Reads then return 08h at address 00h (with carrier clear), 64h at 01h and 00h at 02h.
- R2: A write frame is 16 bits sampled on rising serial clock edges while select is low: bit 0 = 0, then the address [6:0] MSB first, then the data [7:0] MSB first. The register updates on the 16th rising edge.
- R3: A read frame has bit 0 = 1 followed by the address [6:0] MSB first. The register is captured at the 8th rising edge, and its bits 7 down to 0 appear on miso_o from the 8th falling edge onward, one bit per falling edge.
- R4: miso_oe_o is high only from the 8th to the 16th falling edge of a read frame. It is low throughout write frames and while select is high.
- R5: Address 00h: bit 7 reads carrier_i and cannot be written; bit 6 is mute; bits [4:3] are the sleep mode; bit 2 is reach extension; bits 5, 1 and 0 are reserved.
- R6: Address 01h: bits [7:5] are swing, bits [4:2] are offset, and bits [1:0] are reserved.
- R7: Address 02h: bit 7 is the coarse launch setting, bits [6:3] are the fine launch setting, and bits [2:0] are reserved.
- R8: Address 03h is read only. Bits [7:3] return cable_len_i, clamped to 25, and bits [2:0] read 0. Writes to it change nothing.
- R9: Reserved bits read back as 0 whatever was written to them.
- R10: Writes to addresses 04h to 7Fh change no register and are not aliased onto 00h to 03h. Reads from those addresses return 00h.
- R11: A frame that ends before its 16th rising edge changes no register. The next frame, which starts with select low, is decoded from its first bit.
- R12: While en_i is low, writes are ignored and miso_oe_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Access enable; when low, access is blocked |
| sck_i | input | 1 | Serial clock from host |
| mosi_i | input | 1 | Serial data from host |
| ss_ni | input | 1 | Select, active low; reads as high when idle |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Output enable for the miso pad |
| carrier_i | input | 1 | Carrier present status from core |
| cable_len_i | input | 5 | Cable length estimate from core |
| mute_o | output | 1 | Output mute |
| sleep_mode_o | output | 2 | Sleep mode select |
| ext_reach_o | output | 1 | Reach extension enable |
| swing_o | output | 3 | Output swing code |
| offset_o | output | 3 | Output offset code |
| launch_coarse_o | output | 1 | Coarse launch amplitude setting |
| launch_fine_o | output | 4 | Fine launch amplitude setting |

## Verification
The assertions assume a serial clock with high and low phases several system clocks long, and select and enable that change only between frames. Under those conditions every serial edge is seen exactly once after the synchronisers. The bench holds each serial phase for six system clocks, and it changes the data line only while the serial clock is low. The status inputs are set long before the frames that read them, so their synchroniser delay never coincides with a capture.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned HDR_W    = ADDR_W + 1;
  localparam int unsigned FRAME_W  = HDR_W + REG_W;
  localparam int unsigned NUM_RW   = 3;
  localparam int unsigned LEN_W    = 5;
  localparam int unsigned LEN_MAX  = 25;
  localparam int unsigned LEN_LSB  = REG_W - LEN_W;
  localparam int unsigned SYNC_N   = 2;

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(3);

  // reset values and writable-bit masks of the three writable registers
  localparam logic [NUM_RW-1:0][REG_W-1:0] RW_RST  = {8'h00, 8'h64, 8'h08};
  localparam logic [NUM_RW-1:0][REG_W-1:0] RW_MASK = {8'hF8, 8'hFC, 8'h5C};

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } wr_req_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              ss_s_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output wr_req_t           wr_req_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic               sck_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_nxt;
  logic [REG_W-1:0]   tx_q;
  logic               rd_mode_q, oe_q, miso_q;
  logic               active, rise, fall, hdr_done, frame_done;

  assign active     = ~ss_s_i & en_i;
  assign rise       = sck_s_i & ~sck_q;
  assign fall       = ~sck_s_i & sck_q;
  assign sr_nxt     = {sr_q[FRAME_W-2:0], mosi_s_i};
  assign hdr_done   = active && rise && (cnt_q == CNT_W'(HDR_W - 1));
  assign frame_done = active && rise && (cnt_q == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cnt_q     <= '0;
      sr_q      <= '0;
      tx_q      <= '0;
      rd_mode_q <= 1'b0;
      oe_q      <= 1'b0;
      miso_q    <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      if (!active) begin
        cnt_q     <= '0;
        rd_mode_q <= 1'b0;
        oe_q      <= 1'b0;
        miso_q    <= 1'b0;
      end else begin
        if (rise) begin
          sr_q <= sr_nxt;
          if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
        end
        // command bit is the MSB of the completed header byte
        if (hdr_done && sr_nxt[HDR_W-1]) begin
          rd_mode_q <= 1'b1;
          tx_q      <= rd_data_i;
        end
        if (fall && rd_mode_q) begin
          if (cnt_q == CNT_W'(FRAME_W)) begin
            oe_q      <= 1'b0;
            rd_mode_q <= 1'b0;
          end else begin
            oe_q   <= 1'b1;
            miso_q <= tx_q[REG_W-1];
            tx_q   <= {tx_q[REG_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr_o     = sr_nxt[ADDR_W-1:0];
  assign wr_stb_o      = frame_done && !sr_nxt[FRAME_W-1];
  assign wr_req_o.addr = sr_nxt[FRAME_W-2 -: ADDR_W];
  assign wr_req_o.data = sr_nxt[REG_W-1:0];
  assign miso_o        = miso_q;
  assign miso_oe_o     = oe_q;
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  wr_req_t           wr_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              carrier_s_i,
  input  logic [LEN_W-1:0]  len_s_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              mute_o,
  output logic [1:0]        sleep_mode_o,
  output logic              ext_reach_o,
  output logic [2:0]        swing_o,
  output logic [2:0]        offset_o,
  output logic              launch_coarse_o,
  output logic [3:0]        launch_fine_o
);
  logic [NUM_RW-1:0][REG_W-1:0] rw_q;
  logic [LEN_W-1:0]             len_rd;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rw_q[g] <= RW_RST[g];
      else if (wr_stb_i && wr_req_i.addr == ADDR_W'(g))
        rw_q[g] <= wr_req_i.data & RW_MASK[g];
    end
  end

  assign len_rd = (len_s_i > LEN_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : len_s_i;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == STAT_ADDR) begin
      rd_data_o = {len_rd, {LEN_LSB{1'b0}}};
    end else begin
      for (int i = 0; i < NUM_RW; i++)
        if (rd_addr_i == ADDR_W'(i)) rd_data_o = rw_q[i];
      if (rd_addr_i == '0) rd_data_o[REG_W-1] = carrier_s_i;
    end
  end

  assign mute_o          = rw_q[0][6];
  assign sleep_mode_o    = rw_q[0][4:3];
  assign ext_reach_o     = rw_q[0][2];
  assign swing_o         = rw_q[1][7:5];
  assign offset_o        = rw_q[1][4:2];
  assign launch_coarse_o = rw_q[2][7];
  assign launch_fine_o   = rw_q[2][6:3];
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             ss_ni,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             carrier_i,
  input  logic [LEN_W-1:0] cable_len_i,
  output logic             mute_o,
  output logic [1:0]       sleep_mode_o,
  output logic             ext_reach_o,
  output logic [2:0]       swing_o,
  output logic [2:0]       offset_o,
  output logic             launch_coarse_o,
  output logic [3:0]       launch_fine_o
);
  logic [2:0]        pin_s;
  logic [LEN_W:0]    stat_s;
  logic              wr_stb;
  wr_req_t           wr_req;
  logic [ADDR_W-1:0] rd_addr;
  logic [REG_W-1:0]  rd_data;

  // select idles high
  spi_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_pin_sync (
    .clk_i, .rst_ni, .d_i({ss_ni, sck_i, mosi_i}), .q_o(pin_s)
  );

  spi_sync #(.W(LEN_W + 1), .STAGES(SYNC_N), .RST_VAL('0)) u_stat_sync (
    .clk_i, .rst_ni, .d_i({carrier_i, cable_len_i}), .q_o(stat_s)
  );

  spi_frame u_frame (
    .clk_i, .rst_ni, .en_i,
    .sck_s_i(pin_s[1]), .mosi_s_i(pin_s[0]), .ss_s_i(pin_s[2]),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_stb_o(wr_stb), .wr_req_o(wr_req),
    .miso_o, .miso_oe_o
  );

  spi_regs u_regs (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_req_i(wr_req), .rd_addr_i(rd_addr),
    .carrier_s_i(stat_s[LEN_W]), .len_s_i(stat_s[LEN_W-1:0]),
    .rd_data_o(rd_data),
    .mute_o, .sleep_mode_o, .ext_reach_o, .swing_o, .offset_o,
    .launch_coarse_o, .launch_fine_o
  );
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk
  import spi_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              ss_ni,
  input logic              miso_oe_o,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input logic [15:0]       fields
);
  // R4
  ss_idle_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ss_ni) && $past(ss_ni, 2) && $past(ss_ni, 3) && $past(ss_ni, 4)) |-> !miso_oe_o);

  // R12
  disabled_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !miso_oe_o);

  // R11
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> $stable(fields));

  // R9
  rsv_zero_r0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr == ADDR_W'(0)) |-> (rd_data[5] == 1'b0 && rd_data[1:0] == 2'b00));

  // R9
  rsv_zero_r12_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr == ADDR_W'(1)) |-> (rd_data[1:0] == 2'b00));

  // R8
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr == STAT_ADDR) |-> (rd_data[2:0] == 3'b000 && rd_data[7:3] <= 5'd25));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr > STAT_ADDR) |-> (rd_data == '0));
endmodule

bind spi_cfg_ctrl spi_cfg_chk u_chk (
  .clk_i, .rst_ni, .en_i, .ss_ni, .miso_oe_o,
  .wr_stb, .rd_addr, .rd_data,
  .fields({mute_o, sleep_mode_o, ext_reach_o, swing_o, offset_o,
           launch_coarse_o, launch_fine_o, 1'b0})
);

// File: tb/tb_spi_cfg_ctrl.sv
module tb_spi_cfg_ctrl;
  localparam int H = 6;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic carrier = 1'b0;
  logic [4:0] cable_len = 5'd10;
  logic miso, miso_oe, mute, ext_reach, coarse;
  logic [1:0] sleep_mode;
  logic [2:0] swing, offset;
  logic [3:0] fine;

  int checks = 0, fails = 0, oe_err = 0;
  bit done = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  spi_cfg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sck_i(sck), .mosi_i(mosi),
    .ss_ni(ss_n), .miso_o(miso), .miso_oe_o(miso_oe), .carrier_i(carrier),
    .cable_len_i(cable_len), .mute_o(mute), .sleep_mode_o(sleep_mode),
    .ext_reach_o(ext_reach), .swing_o(swing), .offset_o(offset),
    .launch_coarse_o(coarse), .launch_fine_o(fine)
  );

  // {read, addr[6:0], wdata[7:0], expected[7:0]}
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 7'h00, 8'hFF, 8'h00}, {1'b1, 7'h00, 8'h00, 8'h5C},
    {1'b0, 7'h01, 8'hFF, 8'h00}, {1'b1, 7'h01, 8'h00, 8'hFC},
    {1'b0, 7'h02, 8'hFF, 8'h00}, {1'b1, 7'h02, 8'h00, 8'hF8},
    {1'b0, 7'h03, 8'hFF, 8'h00}, {1'b1, 7'h03, 8'h00, 8'h50},
    {1'b0, 7'h05, 8'hAA, 8'h00}, {1'b1, 7'h05, 8'h00, 8'h00},
    {1'b1, 7'h01, 8'h00, 8'hFC}, {1'b1, 7'h7F, 8'h00, 8'h00},
    {1'b0, 7'h00, 8'h10, 8'h00}, {1'b1, 7'h00, 8'h00, 8'h10},
    {1'b0, 7'h01, 8'hA8, 8'h00}, {1'b1, 7'h01, 8'h00, 8'hA8},
    {1'b0, 7'h02, 8'h5B, 8'h00}, {1'b1, 7'h02, 8'h00, 8'h58},
    {1'b1, 7'h03, 8'h00, 8'h50}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rd_cmd, input logic [6:0] addr, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rdat);
    logic [15:0] frm;
    frm = {rd_cmd, addr, wd};
    rdat = '0;
    ss_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      mosi = (rd_cmd && i >= 8) ? 1'b0 : frm[15-i];
      wait_clk(H);
      if (rd_cmd && i >= 8) begin
        rdat[15-i] = miso;
        if (en && !miso_oe) oe_err++;
      end
      if ((!rd_cmd || !en) && miso_oe) oe_err++;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
    wait_clk(H);
    ss_n = 1'b1;
    wait_clk(2 * H);
    if (miso_oe) oe_err++;
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);

    chk(miso_oe == 1'b0, "R4 reset idle", miso_oe, 0);
    chk({mute, sleep_mode, ext_reach} == 4'b0010, "R1 reg00 fields", {mute, sleep_mode, ext_reach}, 4'b0010);
    chk({swing, offset} == 6'b011001, "R1 reg01 fields", {swing, offset}, 6'b011001);
    chk({coarse, fine} == 5'b0, "R1 reg02 fields", {coarse, fine}, 0);
    xfer(1, 7'h00, 8'h00, 16, rd); chk(rd == 8'h08, "R1 R3 read 00h", rd, 8'h08);
    xfer(1, 7'h01, 8'h00, 16, rd); chk(rd == 8'h64, "R1 R3 read 01h", rd, 8'h64);
    xfer(1, 7'h02, 8'h00, 16, rd); chk(rd == 8'h00, "R1 R3 read 02h", rd, 8'h00);

    // R2 R3 R5 R6 R7 R8 R9 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][23], VEC[v][22:16], VEC[v][15:8], 16, rd);
      if (VEC[v][23])
        chk(rd == VEC[v][7:0], $sformatf("R2 R9 R10 vector %0d", v), rd, VEC[v][7:0]);
    end
    chk(oe_err == 0, "R4 oe outside read data phase", oe_err, 0);

    // R5 carrier bit is live and read only
    carrier = 1'b1;
    wait_clk(10);
    xfer(1, 7'h00, 8'h00, 16, rd); chk(rd == 8'h90, "R5 carrier bit", rd, 8'h90);

    xfer(0, 7'h00, 8'h5C, 16, rd);
    chk({mute, sleep_mode, ext_reach} == 4'b1111, "R5 field decode", {mute, sleep_mode, ext_reach}, 4'hF);
    chk({swing, offset} == 6'b101010, "R6 field decode", {swing, offset}, 6'b101010);
    chk({coarse, fine} == 5'b01011, "R7 field decode", {coarse, fine}, 5'b01011);

    // R8 clamp
    cable_len = 5'd31;
    wait_clk(10);
    xfer(1, 7'h03, 8'h00, 16, rd); chk(rd == 8'hC8, "R8 length clamp", rd, 8'hC8);
    cable_len = 5'd25;
    wait_clk(10);
    xfer(1, 7'h03, 8'h00, 16, rd); chk(rd == 8'hC8, "R8 length max", rd, 8'hC8);

    // R11 truncated write, then a full frame
    xfer(0, 7'h01, 8'h00, 12, rd);
    xfer(1, 7'h01, 8'h00, 16, rd); chk(rd == 8'hA8, "R11 truncated write", rd, 8'hA8);
    chk(swing == 3'b101, "R11 swing held", swing, 3'b101);
    xfer(0, 7'h01, 8'h24, 16, rd);
    xfer(1, 7'h01, 8'h00, 16, rd); chk(rd == 8'h24, "R11 next frame decoded", rd, 8'h24);

    // R12 disabled access
    en = 1'b0;
    oe_err = 0;
    xfer(0, 7'h02, 8'h80, 16, rd);
    chk(coarse == 1'b0, "R12 write blocked", coarse, 0);
    xfer(1, 7'h02, 8'h00, 16, rd);
    chk(oe_err == 0, "R12 miso not driven", oe_err, 0);
    en = 1'b1;
    wait_clk(4);
    xfer(1, 7'h02, 8'h00, 16, rd); chk(rd == 8'h58, "R12 reg02 unchanged", rd, 8'h58);
    chk(oe_err == 0, "R4 final oe", oe_err, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule